// File: doc/BRIEF.md
# Constant-Time Element Lookup Permuter

This unit performs a table lookup on packed register data. One operand is read as a small table of equal-width elements and the other as a vector of indices with the same element width. Every index element is replaced by the table element it names. Elements are either 4 bits (nibble mode) or 8 bits (byte mode). An index that names a position past the end of the table yields a zero element. Indices never wrap.

The datapath is 64 bits wide. A width flag selects between full 64-bit operation and 32-bit operation. In 32-bit operation only the low half of each operand takes part and the upper half of the result is zero. The lookup is a fixed network of parallel selectors followed by one register stage. Every operation therefore takes exactly one cycle, whatever the operand values. This matters when the table or the indices hold secret data.

Top module: `xbar_lookup`

## Requirements
- R1: In byte mode (`size_byte`=1) with `wide`=1, result byte j (bits 8j+7..8j) equals table byte k, where k is the value of index byte j and k is 0 to 7.
- R2: In nibble mode (`size_byte`=0) with `wide`=1, result nibble j (bits 4j+3..4j) equals table nibble k, where k is the value of index nibble j. All 16 index values are in range.
- R3: In byte mode with `wide`=1, an index byte with value 8 to 255 produces a zero result byte.
- R4: With `wide`=0 in byte mode, only the low 32 bits of each operand are used. The table has 4 bytes, index values 4 to 255 give zero, result bits 63..32 are zero, and operand bits 63..32 have no effect.
- R5: With `wide`=0 in nibble mode, the table has 8 nibbles taken from bits 31..0. Index nibble values 8 to 15 give zero, and result bits 63..32 are zero.
- R6: The result of an operation accepted with `in_valid`=1 appears on `result_o` together with `out_valid`=1 on the next rising clock edge. This holds for every operand value and for back-to-back operations.
- R7: In a cycle with `in_valid`=0, the next cycle has `out_valid`=0 and `result_o` keeps its previous value, whatever the other inputs do.
- R8: While `rst_n` is low, `out_valid` is 0 and `result_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| size_byte | input | 1 | Element size: 1 = 8-bit, 0 = 4-bit |
| wide | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| table_i | input | 64 | Table operand |
| index_i | input | 64 | Index operand |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result_o | output | 64 | Permuted result |

## Verification
The assertions check on every cycle that the valid flag tracks the strobe with a one-cycle delay. They also check that the result holds during idle cycles, that the upper half is zero in 32-bit operation, and that a vector made only of out-of-range indices gives an all-zero result. The per-element table selection cannot be checked that way and is left to the bench. The bench sweeps every index value through every lane in both element sizes and both widths, and compares each result with an arithmetic shift-and-mask model. The same sweeps show that upper operand bits have no effect in 32-bit operation.

// File: rtl/xbl_pkg.sv
package xbl_pkg;
  typedef enum logic {
    ESZ_NIB  = 1'b0,
    ESZ_BYTE = 1'b1
  } esz_e;

  // number of elements of width ew in a datapath of width w
  function automatic int elem_count(input int w, input int ew);
    return w / ew;
  endfunction
endpackage

// File: rtl/xbl_lane.sv
// One result element: selects the table element addressed by idx,
// or zero when idx is past the active table length.
module xbl_lane #(
  parameter int XLEN = 64,
  parameter int EW   = 8
) (
  input  logic [XLEN-1:0] tbl,
  input  logic [EW-1:0]   idx,
  input  logic            wide,
  output logic [EW-1:0]   elem
);
  localparam int N    = xbl_pkg::elem_count(XLEN, EW);
  localparam int NLOW = N / 2;

  always_comb begin
    elem = '0;
    for (int k = 0; k < N; k++) begin
      if ((idx == EW'(k)) && (wide || (k < NLOW))) begin
        elem = tbl[k*EW +: EW];
      end
    end
  end
endmodule

// File: rtl/xbl_array.sv
// All lanes of one element size; lanes above the active width give zero.
module xbl_array #(
  parameter int XLEN = 64,
  parameter int EW   = 8
) (
  input  logic [XLEN-1:0] tbl,
  input  logic [XLEN-1:0] idx,
  input  logic            wide,
  output logic [XLEN-1:0] res
);
  localparam int N    = xbl_pkg::elem_count(XLEN, EW);
  localparam int NLOW = N / 2;

  for (genvar j = 0; j < N; j++) begin : g_lane
    logic [EW-1:0] sel;

    xbl_lane #(.XLEN(XLEN), .EW(EW)) u_lane (
      .tbl  (tbl),
      .idx  (idx[j*EW +: EW]),
      .wide (wide),
      .elem (sel)
    );

    if (j < NLOW) begin : g_low
      assign res[j*EW +: EW] = sel;
    end else begin : g_high
      assign res[j*EW +: EW] = wide ? sel : '0;
    end
  end
endmodule

// File: rtl/xbar_lookup.sv
module xbar_lookup #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            size_byte,
  input  logic            wide,
  input  logic [XLEN-1:0] table_i,
  input  logic [XLEN-1:0] index_i,
  output logic            out_valid,
  output logic [XLEN-1:0] result_o
);
  import xbl_pkg::*;

  logic [XLEN-1:0] nib_res;
  logic [XLEN-1:0] byte_res;
  logic [XLEN-1:0] res_nxt;
  logic [XLEN-1:0] res_q;
  logic            vld_q;
  esz_e            esz;

  assign esz = esz_e'(size_byte);

  xbl_array #(.XLEN(XLEN), .EW(4)) u_nib (
    .tbl  (table_i),
    .idx  (index_i),
    .wide (wide),
    .res  (nib_res)
  );

  xbl_array #(.XLEN(XLEN), .EW(8)) u_byte (
    .tbl  (table_i),
    .idx  (index_i),
    .wide (wide),
    .res  (byte_res)
  );

  always_comb begin
    res_nxt = (esz == ESZ_BYTE) ? byte_res : nib_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        res_q <= res_nxt;
      end
    end
  end

  assign out_valid = vld_q;
  assign result_o  = res_q;
endmodule

// File: rtl/xbl_chk.sv
module xbl_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            size_byte,
  input logic            wide,
  input logic [XLEN-1:0] index_i,
  input logic            out_valid,
  input logic [XLEN-1:0] result_o
);
  localparam int NB = XLEN / 8;
  localparam int NN = XLEN / 4;

  logic all_oob;

  always_comb begin
    all_oob = 1'b1;
    if (size_byte) begin
      for (int j = 0; j < NB; j++) begin
        if ((wide || (j < NB/2)) &&
            (int'(index_i[j*8 +: 8]) < (wide ? NB : NB/2))) begin
          all_oob = 1'b0;
        end
      end
    end else if (wide) begin
      all_oob = 1'b0;
    end else begin
      for (int j = 0; j < NN/2; j++) begin
        if (int'(index_i[j*4 +: 4]) < NN/2) begin
          all_oob = 1'b0;
        end
      end
    end
  end

  // R6
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result_o)));

  // R4
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide) |=> (result_o[XLEN-1:XLEN/2] == '0));

  // R3
  oob_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && all_oob) |=> (result_o == '0));

  // R8
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert (!out_valid && (result_o == '0));
    end
  end
endmodule

bind xbar_lookup xbl_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .size_byte (size_byte),
  .wide      (wide),
  .index_i   (index_i),
  .out_valid (out_valid),
  .result_o  (result_o)
);

// File: tb/sim_xbar_lookup.sv
`timescale 1ns/1ps
module sim_xbar_lookup;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        size_byte;
  logic        wide;
  logic [63:0] table_i;
  logic [63:0] index_i;
  logic        out_valid;
  logic [63:0] result_o;

  int checks;
  int errors;
  bit done;

  xbar_lookup #(.XLEN(64)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_byte(size_byte),
    .wide(wide), .table_i(table_i), .index_i(index_i),
    .out_valid(out_valid), .result_o(result_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [63:0] model(input bit sb, input bit w,
                                        input logic [63:0] t, input logic [63:0] ix);
    int ew, n, k;
    logic [63:0] r, m;
    ew = sb ? 8 : 4;
    n  = (w ? 64 : 32) / ew;
    m  = (64'd1 << ew) - 64'd1;
    r  = '0;
    for (int j = 0; j < n; j++) begin
      k = int'((ix >> (j*ew)) & m);
      if (k < n) r |= ((t >> (k*ew)) & m) << (j*ew);
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input string tag, input bit sb, input bit w,
                    input logic [63:0] t, input logic [63:0] ix);
    @(negedge clk);
    in_valid = 1'b1; size_byte = sb; wide = w; table_i = t; index_i = ix;
    @(negedge clk);
    in_valid = 1'b0;
    chk(tag, {63'd0, out_valid}, 64'd1);
    chk(tag, result_o, model(sb, w, t, ix));
  endtask

  function automatic logic [63:0] rep_idx(input int v, input int ew, input int step);
    logic [63:0] r;
    r = '0;
    for (int j = 0; j < 64/ew; j++)
      r |= (64'((v + step*j) % (1 << ew))) << (j*ew);
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] t, saved, ix, prev_t, prev_ix;
    bit prev_sb, prev_w;
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; in_valid = 1'b0; size_byte = 1'b0; wide = 1'b1;
    table_i = '1; index_i = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 valid", {63'd0, out_valid}, 64'd0);
    chk("R8 result", result_o, 64'd0);
    rst_n = 1'b1;

    // R1 in-range byte permutations
    t = 64'h8877_6655_4433_2211;
    for (int v = 0; v < 8; v++) op("R1", 1, 1, t, rep_idx(v, 8, 3) & 64'h0707_0707_0707_0707);
    for (int v = 0; v < 8; v++) op("R1", 1, 1, {$urandom, $urandom}, rep_idx(v, 8, 5) & 64'h0707_0707_0707_0707);

    // R3 every byte index value in every lane
    for (int v = 0; v < 256; v++) op("R3", 1, 1, {$urandom, $urandom}, rep_idx(v, 8, 37));
    op("R3 all oob", 1, 1, 64'hffff_ffff_ffff_ffff, 64'h08ff_8010_4020_0909);

    // R2 every nibble index in every lane
    for (int v = 0; v < 16; v++) op("R2", 0, 1, 64'hfedc_ba98_7654_3210, rep_idx(v, 4, 7));
    for (int v = 0; v < 64; v++) op("R2", 0, 1, {$urandom, $urandom}, rep_idx(v, 4, v % 16));

    // R4 narrow byte, random upper operand bits
    for (int v = 0; v < 256; v++) op("R4", 1, 0, {$urandom, $urandom}, {$urandom, 32'h0} | (rep_idx(v, 8, 11) & 64'hffff_ffff));
    op("R4 upper ignored", 1, 0, 64'hdead_beef_0403_0201, 64'h0001_0203_0003_0102);

    // R5 narrow nibble
    for (int v = 0; v < 16; v++) op("R5", 0, 0, {$urandom, $urandom}, {$urandom, 32'h0} | (rep_idx(v, 4, 3) & 64'hffff_ffff));
    op("R5 all oob", 0, 0, 64'h1234_5678_9abc_def1, 64'h0000_0000_f8f9_abce);

    // R6 back-to-back operations
    prev_sb = 0; prev_w = 0; prev_t = '0; prev_ix = '0;
    for (int i = 0; i < 41; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk("R6 valid", {63'd0, out_valid}, 64'd1);
        chk("R6 result", result_o, model(prev_sb, prev_w, prev_t, prev_ix));
      end
      prev_sb = ($urandom % 2) == 1; prev_w = ($urandom % 2) == 1;
      prev_t = {$urandom, $urandom}; prev_ix = {$urandom, $urandom} & 64'h0f0f_0f0f_0f0f_0f0f;
      in_valid = 1'b1; size_byte = prev_sb; wide = prev_w; table_i = prev_t; index_i = prev_ix;
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6 last", result_o, model(prev_sb, prev_w, prev_t, prev_ix));

    // R7 hold while idle with changing inputs
    saved = result_o;
    for (int i = 0; i < 4; i++) begin
      table_i = {$urandom, $urandom}; index_i = '0; size_byte = ~size_byte;
      @(negedge clk);
      chk("R7 valid", {63'd0, out_valid}, 64'd0);
      chk("R7 hold", result_o, saved);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule